// File: doc/BRIEF.md
# Serial Frame Address Recognition Filter

This block sits beside a multiprocessor-capable serial receiver and decides whether an incoming address byte is meant for this node. Software loads two registers through a small write port: a node address and a per-bit enable mask. Each received address byte is compared twice. The first comparison is against the node address on the mask's set bits only. The second is against a broadcast pattern, which is the OR of the two registers and in which only set bits count. A hit on either comparison selects the node.

When multiprocessor mode is on, address frames that hit raise the receive interrupt and select the node. Address frames that miss are swallowed and deselect the node. Data frames are passed to the interrupt only while the node is selected. When the mode is off, every received byte raises the interrupt. Because masked-out bits are don't-care, one node can answer several directed addresses. Both registers clear to zero at reset, and in that state every address byte is accepted.

Top module: `node_addr_filter`

## Requirements
- R1: After reset, the node address and mask registers both read back 0x00, the `accept` and `rxIrq` outputs are low, and `selected` is low.
- R2: A write with `regWrEn` high loads `regWrData` into the node address when `regSel` is 0 and into the mask when `regSel` is 1. `regRdData` shows the register chosen by `regSel`.
- R3: The directed match holds when the received byte equals the node address on every bit where the mask is 1. Bits where the mask is 0 are ignored.
- R4: The broadcast match holds when the received byte has a 1 in every bit where (address OR mask) is 1. Bits where that OR is 0 are ignored. With address 0xF1 and mask 0xFB, the byte 0xFF is accepted and 0xF3 is rejected.
- R5: With both registers at their reset value 0x00, every address byte is accepted in multiprocessor mode.
- R6: `accept` and `rxIrq` are registered. They reflect a strobed frame in the cycle after the `rxStrobe` cycle, and they are low in any cycle that follows a cycle without `rxStrobe`.
- R7: With `mpMode` low, every strobed byte raises `rxIrq`, `accept` stays low, and `selected` keeps its value.
- R8: With `mpMode` high, an address frame (`rxAddrFrame` = 1) that matches raises both `accept` and `rxIrq` and sets `selected`.
- R9: With `mpMode` high, an address frame that matches neither pattern leaves `accept` and `rxIrq` low and clears `selected`.
- R10: With `mpMode` high, a data frame (`rxAddrFrame` = 0) raises `rxIrq` exactly when `selected` was set before it. `accept` stays low and `selected` does not change.
- R11: With address 0xF1 and mask 0xFB, both 0xF1 and 0xF5 are accepted as directed addresses, and 0x71 is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 1 | Register select: 0 selects the node address, 1 selects the mask |
| regWrData | input | W | Register write data |
| regRdData | output | W | Read-back of the selected register |
| mpMode | input | 1 | Multiprocessor filtering enable |
| rxStrobe | input | 1 | One-cycle pulse when a received byte is ready |
| rxAddrFrame | input | 1 | Frame is an address frame (ninth bit set) |
| rxByte | input | W | Received byte |
| accept | output | 1 | Registered pulse: an address frame matched |
| rxIrq | output | 1 | Registered pulse: receive interrupt passed through |
| selected | output | 1 | Node is currently selected for data frames |

## Verification
The bench builds the block with its default width of 8 bits. At that width, random received bytes, addresses and masks cover the whole byte space, so directed hits, broadcast-only hits and near misses all occur in the same run. The selection state is followed through long mixed runs of address and data frames, with the mode toggled in between, and compared with a bench model. Directed cases fix the reset all-don't-care state and the two-addresses-one-node configuration.

// File: rtl/naf_pkg.sv
package naf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrAddr;
    logic wrMask;
  } naf_strobe_t;
endpackage

// File: rtl/naf_datapath.sv
module naf_datapath
  import naf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  naf_strobe_t strobes,
  input  logic [W-1:0] wrData,
  input  logic        rdSel,
  input  logic [W-1:0] rxByte,
  output logic [W-1:0] rdData,
  output logic        hit
);
  logic [W-1:0] nodeAddr;
  logic [W-1:0] nodeMask;
  logic [W-1:0] dirBit;
  logic [W-1:0] bcBit;
  logic [W-1:0] bcPattern;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nodeAddr <= '0;
      nodeMask <= '0;
    end else begin
      if (strobes.wrAddr) nodeAddr <= wrData;
      if (strobes.wrMask) nodeMask <= wrData;
    end
  end

  assign bcPattern = nodeAddr | nodeMask;

  // Per-bit match terms
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dirBit[i] = ~nodeMask[i] | ~(rxByte[i] ^ nodeAddr[i]);
    assign bcBit[i]  = ~bcPattern[i] | rxByte[i];
  end

  assign hit    = (&dirBit) | (&bcBit);
  assign rdData = rdSel ? nodeMask : nodeAddr;
endmodule

// File: rtl/naf_control.sv
module naf_control
  import naf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic        mpMode,
  input  logic        rxStrobe,
  input  logic        rxAddrFrame,
  input  logic        hit,
  output naf_strobe_t strobes,
  output logic        accept,
  output logic        rxIrq,
  output logic        selected
);
  logic acceptNext;
  logic irqNext;
  logic selNext;

  always_comb begin
    strobes.wrAddr = regWrEn & ~regSel;
    strobes.wrMask = regWrEn & regSel;
  end

  always_comb begin
    acceptNext = 1'b0;
    irqNext    = 1'b0;
    selNext    = selected;
    if (rxStrobe) begin
      if (!mpMode) begin
        irqNext = 1'b1;
      end else if (rxAddrFrame) begin
        acceptNext = hit;
        irqNext    = hit;
        selNext    = hit;
      end else begin
        irqNext = selected;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept   <= 1'b0;
      rxIrq    <= 1'b0;
      selected <= 1'b0;
    end else begin
      accept   <= acceptNext;
      rxIrq    <= irqNext;
      selected <= selNext;
    end
  end
endmodule

// File: rtl/node_addr_filter.sv
module node_addr_filter
  import naf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic [W-1:0] regWrData,
  output logic [W-1:0] regRdData,
  input  logic         mpMode,
  input  logic         rxStrobe,
  input  logic         rxAddrFrame,
  input  logic [W-1:0] rxByte,
  output logic         accept,
  output logic         rxIrq,
  output logic         selected
);
  naf_strobe_t strobes;
  logic        hit;

  naf_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .mpMode(mpMode), .rxStrobe(rxStrobe), .rxAddrFrame(rxAddrFrame),
    .hit(hit), .strobes(strobes), .accept(accept), .rxIrq(rxIrq),
    .selected(selected)
  );

  naf_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .rdSel(regSel), .rxByte(rxByte), .rdData(regRdData), .hit(hit)
  );
endmodule

// File: rtl/naf_checker.sv
module naf_checker (
  input logic clk,
  input logic rstN,
  input logic mpMode,
  input logic rxStrobe,
  input logic rxAddrFrame,
  input logic accept,
  input logic rxIrq,
  input logic selected
);
  // R6: no strobe means quiet outputs next cycle
  a_r6_quiet_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !rxStrobe |=> (!accept && !rxIrq));

  // R7: mode off passes every byte, never accepts, keeps selection
  a_r7_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && !mpMode) |=> (rxIrq && !accept && $stable(selected)));

  // R8 / R9: address frame outcome is consistent across outputs
  a_r8_addr_outcome: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && mpMode && rxAddrFrame) |=> (accept == rxIrq && selected == accept));

  // R10: data frame gated by prior selection
  a_r10_data_gate: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && mpMode && !rxAddrFrame) |=> (rxIrq == $past(selected) && !accept && $stable(selected)));
endmodule

bind node_addr_filter naf_checker u_chk (
  .clk(clk), .rstN(rstN), .mpMode(mpMode), .rxStrobe(rxStrobe),
  .rxAddrFrame(rxAddrFrame), .accept(accept), .rxIrq(rxIrq),
  .selected(selected)
);

// File: tb/node_addr_filter_tb.sv
`timescale 1ns/1ps
module node_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       mpMode = 1'b0;
  logic       rxStrobe = 1'b0;
  logic       rxAddrFrame = 1'b0;
  logic [7:0] rxByte = '0;
  logic       accept, rxIrq, selected;

  int checks = 0;
  int failures = 0;
  logic [7:0] mAddr = '0;
  logic [7:0] mMask = '0;
  logic       mSel = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  node_addr_filter #(.W(8)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mpMode(mpMode),
    .rxStrobe(rxStrobe), .rxAddrFrame(rxAddrFrame), .rxByte(rxByte),
    .accept(accept), .rxIrq(rxIrq), .selected(selected)
  );

  function automatic bit dirMatch(input logic [7:0] b, a, m);
    return ((b ^ a) & m) == 8'h00;
  endfunction

  function automatic bit bcMatch(input logic [7:0] b, a, m);
    return (b & (a | m)) == (a | m);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) mMask = d; else mAddr = d;
  endtask

  task automatic readCheck(input logic sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    regSel = sel;
    #1 chk(req, regRdData, exp);
  endtask

  // Send one frame and check outputs against the model
  task automatic sendFrame(input logic [7:0] b, input logic isAddr, input string req);
    logic expAcc, expIrq, expSel;
    expAcc = 1'b0; expIrq = 1'b0; expSel = mSel;
    if (!mpMode) expIrq = 1'b1;
    else if (isAddr) begin
      expAcc = dirMatch(b, mAddr, mMask) | bcMatch(b, mAddr, mMask);
      expIrq = expAcc; expSel = expAcc;
    end else expIrq = mSel;
    @(negedge clk);
    rxStrobe = 1'b1; rxByte = b; rxAddrFrame = isAddr;
    @(negedge clk);
    rxStrobe = 1'b0;
    chk({req, " accept"}, {7'b0, accept}, {7'b0, expAcc});
    chk({req, " irq"}, {7'b0, rxIrq}, {7'b0, expIrq});
    chk({req, " selected"}, {7'b0, selected}, {7'b0, expSel});
    mSel = expSel;
    @(negedge clk);
    chk("R6 pulse ends", {6'b0, accept, rxIrq}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readCheck(1'b0, 8'h00, "R1 addr reset");
    readCheck(1'b1, 8'h00, "R1 mask reset");
    chk("R1 outputs reset", {5'b0, accept, rxIrq, selected}, 8'h00);
    // R5 all don't-care
    mpMode = 1'b1;
    sendFrame(8'h00, 1'b1, "R5 any byte 00");
    sendFrame(8'h5A, 1'b1, "R5 any byte 5A");
    sendFrame(8'hFF, 1'b1, "R5 any byte FF");
    // R2 write/readback
    writeReg(1'b0, 8'hF1);
    writeReg(1'b1, 8'hFB);
    readCheck(1'b0, 8'hF1, "R2 addr readback");
    readCheck(1'b1, 8'hFB, "R2 mask readback");
    // R11 two addresses one node
    sendFrame(8'hF1, 1'b1, "R11 F1");
    chk("R11 F1 accepted", {7'b0, mSel}, 8'h01);
    sendFrame(8'hF5, 1'b1, "R11 F5");
    chk("R11 F5 accepted", {7'b0, mSel}, 8'h01);
    sendFrame(8'h12, 1'b0, "R10 data while selected");
    sendFrame(8'h71, 1'b1, "R11 R9 71 rejected");
    chk("R9 deselected", {7'b0, mSel}, 8'h00);
    sendFrame(8'h34, 1'b0, "R10 data while deselected");
    // R4 broadcast
    sendFrame(8'hFF, 1'b1, "R4 FF broadcast");
    chk("R4 FF accepted", {7'b0, mSel}, 8'h01);
    sendFrame(8'hF3, 1'b1, "R4 F3 rejected");
    chk("R4 F3 rejected", {7'b0, mSel}, 8'h00);
    // R7 mode off
    mpMode = 1'b0;
    sendFrame(8'h00, 1'b1, "R7 mode off addr");
    sendFrame(8'h99, 1'b0, "R7 mode off data");
    // Random phase: R3 R4 R8 R9 R10 R7
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) writeReg(1'b0, 8'($urandom));
      else if (r == 1) writeReg(1'b1, 8'($urandom));
      else begin
        mpMode = ($urandom_range(0, 7) != 0);
        if (mpMode && $urandom_range(0, 2) == 0)
          sendFrame(mAddr ^ (8'($urandom) & ~mMask), 1'b1, "R3 masked directed");
        else
          sendFrame(8'($urandom), 1'($urandom), "R8 R9 R10 random");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule